// File: doc/BRIEF.md
# Mesh Router Output-Port Decoder

This block chooses the output port for one router in a two-dimensional mesh where memory is spread across cluster caches. The destination cluster sits in the top byte of a 40-bit request address. The upper nibble of that byte is the column and the lower nibble is the row. The router knows its own column and row from two coordinate inputs.

The block compares the destination with its own position and routes in dimension order. It moves along X until the column matches, then along Y. It drives one of five one-hot port lines.

A band of top-byte values above the top mesh row forms an IO window. Requests in this window are flagged, and X-first routing carries them to the top-right router, which sends them out of its north port. Any other off-mesh destination is flagged as a decode error and is delivered to the local port. By default the decision is registered, which adds one cycle of latency.

Top module: `mesh_port_decoder`

## Requirements
- R1: The destination column is `req_addr[39:36]` and the destination row is `req_addr[35:32]`. Bits `[31:0]` have no effect on any output.
- R2: If the destination column is greater than `my_x`, the east port is chosen. If it is less, the west port is chosen. This holds whatever the rows are.
- R3: If the columns are equal, a greater destination row selects north, a smaller one selects south, and an equal one selects local.
- R4: `port_sel` is one-hot: bit 0 is local, bit 1 east, bit 2 west, bit 3 north and bit 4 south.
- R5: A top byte from 0x36 to 0x3F inclusive sets `io_hit`. This is the 40 GB window starting at 0x36_0000_0000. Such a request never raises `dec_err` and follows the rules of R2 and R3, so router (3,5) sends it north.
- R6: A destination outside the 4-column by 6-row mesh that is not in the IO window sets `dec_err` and selects local.
- R7: With `REGISTERED=1` (the default), the outputs change only at the rising clock edge after the inputs are applied, which is one cycle of latency.
- R8: While `rst_n` is low, `port_sel` is local (5'b00001) and `io_hit` and `dec_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 40 | Request address; the top byte selects the destination |
| my_x | input | 4 | Column of this router |
| my_y | input | 4 | Row of this router |
| port_sel | output | 5 | One-hot output port choice |
| io_hit | output | 1 | Request lies in the IO window |
| dec_err | output | 1 | Destination is off the mesh and not IO |

## Verification
The assertions assume that the router's own coordinates lie inside the mesh (`my_x` < 4, `my_y` < 6), because the direction rules only make sense for a router that exists. The stimulus keeps to this by sweeping `my_x` and `my_y` only over real router positions. For each position it applies all 256 top-byte values, with changing low address bits. This covers every in-mesh destination, every IO value and every off-mesh value from every router.

// File: rtl/mesh_port_decoder.sv
module mesh_port_decoder #(
  parameter int ADDR_W = 40,
  parameter int X_W = 4,
  parameter int Y_W = 4,
  parameter int MESH_X = 4,
  parameter int MESH_Y = 6,
  parameter logic [39:0] IO_BASE = 40'h36_0000_0000,
  parameter logic [39:0] IO_SIZE = 40'h0A_0000_0000,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [X_W-1:0]    my_x,
  input  logic [Y_W-1:0]    my_y,
  output logic [4:0]        port_sel,
  output logic              io_hit,
  output logic              dec_err
);
  localparam int TOP_W = X_W + Y_W;
  localparam int LOW_W = ADDR_W - TOP_W;
  localparam logic [39:0] IO_END = IO_BASE + IO_SIZE - 40'd1;
  localparam logic [TOP_W-1:0] IO_LO = TOP_W'(IO_BASE >> LOW_W);
  localparam logic [TOP_W-1:0] IO_HI = TOP_W'(IO_END >> LOW_W);
  localparam logic [X_W-1:0] LIM_X = X_W'(MESH_X);
  localparam logic [Y_W-1:0] LIM_Y = Y_W'(MESH_Y);
  localparam int P_LOC = 0, P_E = 1, P_W = 2, P_N = 3, P_S = 4;

  logic [TOP_W-1:0] dst;
  logic [X_W-1:0]   dst_x;
  logic [Y_W-1:0]   dst_y;
  logic             unused_low;
  logic             in_io, off_mesh, bad;
  logic [4:0]       nxt_sel;

  assign dst        = req_addr[ADDR_W-1:LOW_W];
  assign dst_x      = dst[TOP_W-1:Y_W];
  assign dst_y      = dst[Y_W-1:0];
  assign unused_low = ^req_addr[LOW_W-1:0];

  assign in_io    = (dst >= IO_LO) && (dst <= IO_HI);
  assign off_mesh = (dst_x >= LIM_X) || (dst_y >= LIM_Y);
  assign bad      = off_mesh && !in_io;

  always_comb begin
    nxt_sel = '0;
    if (bad)                nxt_sel[P_LOC] = 1'b1;
    else if (dst_x > my_x)  nxt_sel[P_E] = 1'b1;
    else if (dst_x < my_x)  nxt_sel[P_W] = 1'b1;
    else if (dst_y > my_y)  nxt_sel[P_N] = 1'b1;
    else if (dst_y < my_y)  nxt_sel[P_S] = 1'b1;
    else                    nxt_sel[P_LOC] = 1'b1;
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          port_sel <= 5'b00001;
          io_hit   <= 1'b0;
          dec_err  <= 1'b0;
        end else begin
          port_sel <= nxt_sel;
          io_hit   <= in_io;
          dec_err  <= bad;
        end
      end

      // R7
      lat_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (port_sel == $past(nxt_sel)) && (io_hit == $past(in_io)) && (dec_err == $past(bad)));
    end else begin : g_comb
      assign port_sel = nxt_sel;
      assign io_hit   = in_io;
      assign dec_err  = bad;
    end
  endgenerate

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_sel) == 1);
  // R6
  err_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> port_sel == 5'b00001);
  // R5
  io_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> !dec_err);
  // R2
  east_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_sel[P_E] |-> (dst_x > my_x) && !off_mesh || (dst_x > my_x) && in_io);
  // R3
  ns_after_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_sel[P_N] || nxt_sel[P_S]) |-> dst_x == my_x);
endmodule

// File: tb/test_mesh_port_decoder.sv
`timescale 1ns/1ps
module test_mesh_port_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] req_addr = '0;
  logic [3:0]  my_x = '0;
  logic [3:0]  my_y = '0;
  logic [4:0]  port_sel;
  logic        io_hit;
  logic        dec_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mesh_port_decoder i_mesh_port_decoder (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .my_x(my_x), .my_y(my_y),
    .port_sel(port_sel), .io_hit(io_hit), .dec_err(dec_err)
  );

  function automatic logic [6:0] expect_out(input logic [7:0] b, input int mx, input int my);
    int dx, dy;
    logic io, er;
    logic [4:0] s;
    dx = int'(b[7:4]);
    dy = int'(b[3:0]);
    io = (b >= 8'h36) && (b <= 8'h3F);
    er = !io && (dx >= 4 || dy >= 6);
    if (er)           s = 5'b00001;
    else if (dx > mx) s = 5'b00010;
    else if (dx < mx) s = 5'b00100;
    else if (dy > my) s = 5'b01000;
    else if (dy < my) s = 5'b10000;
    else              s = 5'b00001;
    return {s, io, er};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got sel=%b io=%b err=%b expected sel=%b io=%b err=%b",
               req, act[6:2], act[1], act[0], exp[6:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    logic [6:0] prev;
    logic [6:0] exp;
    logic [6:0] first;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check("R8", {port_sel, io_hit, dec_err}, 7'b0000100);
    @(negedge clk);
    rst_n = 1'b1;
    prev = 7'b0000100;
    // R1 R2 R3 R4 R5 R6 R7: every router position against every top byte
    for (int mx = 0; mx < 4; mx++) begin
      for (int my = 0; my < 6; my++) begin
        for (int b = 0; b < 256; b++) begin
          @(negedge clk);
          my_x = 4'(mx);
          my_y = 4'(my);
          req_addr = {8'(b), 32'(b * 32'h9E37_79B1 + mx * 7 + my)};
          exp = expect_out(8'(b), mx, my);
          #1;
          check("R7", {port_sel, io_hit, dec_err}, prev);
          @(posedge clk);
          #1;
          if (exp[1])       check("R5", {port_sel, io_hit, dec_err}, exp);
          else if (exp[0])  check("R6", {port_sel, io_hit, dec_err}, exp);
          else if (b[7:4] != mx[3:0]) check("R2", {port_sel, io_hit, dec_err}, exp);
          else              check("R3", {port_sel, io_hit, dec_err}, exp);
          checks++;
          if ($countones(port_sel) != 1) begin
            errors++;
            $display("FAIL R4: got sel=%b expected one-hot", port_sel);
          end
          prev = exp;
        end
      end
    end
    // R1 low address bits have no effect
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      my_x = 4'(k % 4);
      my_y = 4'(k % 6);
      req_addr = {8'(k * 17), 32'h0000_0000};
      @(posedge clk);
      #1;
      first = {port_sel, io_hit, dec_err};
      @(negedge clk);
      req_addr[31:0] = 32'hFFFF_FFFF ^ 32'(k << 5);
      @(posedge clk);
      #1;
      check("R1", {port_sel, io_hit, dec_err}, first);
      check("R1", {port_sel, io_hit, dec_err}, expect_out(8'(k * 17), k % 4, k % 6));
    end
    // R5 IO path at corner router (3,5) leaves north
    @(negedge clk);
    my_x = 4'd3; my_y = 4'd5; req_addr = 40'h36_0000_0000;
    @(posedge clk); #1;
    check("R5", {port_sel, io_hit, dec_err}, 7'b0100010);
    @(negedge clk);
    req_addr = 40'h3F_FFFF_FFFF;
    @(posedge clk); #1;
    check("R5", {port_sel, io_hit, dec_err}, 7'b0100010);
    @(negedge clk);
    req_addr = 40'h40_0000_0000;
    @(posedge clk); #1;
    check("R6", {port_sel, io_hit, dec_err}, 7'b0000101);
    // R8 reset reasserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", {port_sel, io_hit, dec_err}, 7'b0000100);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule